// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Register Bank

This block holds a small bank of interrupt mask and priority registers behind a simple write/read port. A register is either a dual register, reached through one address whose write ORs the data into the stored value and a second address whose write clears the data bits, or a priority register written directly through a single address. Each register is cut into fields. Mask registers have one-bit fields and priority registers have wider ones. Every field is tied to an interrupt identifier.

When an accepted write changes one or more fields, the bank turns each change into an enable event for the field's identifier: an increment when the new field value is nonzero and a decrement when it is zero. An identifier without a vector is a group. Its event travels down a linked chain of member identifiers, one member per clock. While events are still being issued, the write port reports not-ready. Pending tracking and vector arbitration sit downstream and take the event stream as their input.

Top module: `intc_mask_bank`

## Requirements
- R1: During and after reset all registers read 0, `wr_ready` is 1, `ev_valid` and `wr_err` are 0, and a reset asserted while events are pending drops the rest of them.
- R2: Addresses match on bits [28:0] only, so bits [31:29] of both `wr_addr` and `rd_addr` are ignored.
- R3: A write to a dual register's set address stores old OR data. A write to its clear address stores old AND NOT data.
- R4: A write to a priority register that has only a set address stores the data unchanged. Reading any mapped address of a register returns its stored value on `rd_data` one cycle after `rd_en`. An unmapped read returns 0.
- R5: An accepted write to an unmapped address, or to a register with no supported write mode (a mask register with a single address), pulses `wr_err` for one cycle. It stores nothing and emits no event.
- R6: A register of width W with field width F has W/F fields. Field k occupies bits starting at (W/F-1-k)*F, so field 0 is the most significant. Changed fields are handled in increasing k. Each changed field yields an event with `ev_inc`=1 if its new value is nonzero and 0 if it is zero. Unchanged fields yield nothing.
- R7: Identifier 0, and any identifier with neither a vector nor a chain successor (reserved), produces no event.
- R8: An identifier without a vector walks its chain, one member per cycle. Each member that has a vector gets the same event. The walk passes through every member and ends at a successor of 0. A field whose own identifier has a vector does not walk its successor.
- R9: `wr_ready` is low while events remain to be issued. A write presented while `wr_ready` is low is ignored and leaves every register unchanged.
- R10: Events appear on registered outputs, at most one per cycle, each as a single-cycle `ev_valid` pulse, and only while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 32 | Write address |
| wr_data | input | 8 | Write data |
| wr_ready | output | 1 | Write is accepted on this cycle's edge when high |
| wr_err | output | 1 | One-cycle pulse after an accepted write with no valid target |
| rd_en | input | 1 | Read request |
| rd_addr | input | 32 | Read address |
| rd_data | output | 8 | Registered read data |
| ev_valid | output | 1 | Enable event present |
| ev_id | output | 4 | Identifier the event applies to |
| ev_inc | output | 1 | 1 = enable increment, 0 = enable decrement |

## Verification
The bench aims at the field-order and chain corner cases. A write that changes every field of a mask register must produce events from the most significant field down, with a group expanded through a member that has no vector, and with an identifier-0 field and a reserved field left silent. A design that scanned fields from the low end, stopped a chain at a vectorless member, or let a vectored field follow its successor would issue the events in the wrong order, in the wrong number, or with the wrong identifiers. A priority field that changes between two nonzero values must still increment. Writes that alias through the top address bits, writes to an unsupported register, and a write offered while the bank is busy are all checked by reading the registers back. A design that got these wrong would either miss the aliased register or store data it should have refused.

// File: rtl/intc_bank_pkg.sv
package intc_bank_pkg;

  // Decoded action of a write access
  typedef enum logic [2:0] {
    WM_NONE   = 3'd0,  // no register at this address
    WM_SET    = 3'd1,  // dual register, OR-in address
    WM_CLR    = 3'd2,  // dual register, clear address
    WM_DIRECT = 3'd3,  // priority register, plain store
    WM_BAD    = 3'd4   // register found, write mode unsupported
  } wmode_e;

  localparam int MATCH_W = 29;  // address bits taking part in the compare

endpackage

// File: rtl/ibank_decode.sv
module ibank_decode
  import intc_bank_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int IW   = 2,
  parameter logic [NREG-1:0][AW-1:0] SET_ADDR = '0,
  parameter logic [NREG-1:0][AW-1:0] CLR_ADDR = '0,
  parameter logic [NREG-1:0]         IS_PRIO  = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output wmode_e        mode
);

  logic unused_hi;
  assign unused_hi = ^addr[AW-1:MATCH_W];

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    mode = WM_NONE;
    // descending scan so the lowest-numbered register wins
    for (int r = NREG - 1; r >= 0; r--) begin
      logic has_s, has_c, m_s, m_c;
      has_s = (SET_ADDR[r][MATCH_W-1:0] != '0);
      has_c = (CLR_ADDR[r][MATCH_W-1:0] != '0);
      m_s   = has_s && (addr[MATCH_W-1:0] == SET_ADDR[r][MATCH_W-1:0]);
      m_c   = has_c && (addr[MATCH_W-1:0] == CLR_ADDR[r][MATCH_W-1:0]);
      if (m_s || m_c) begin
        hit = 1'b1;
        idx = IW'(r);
        if (has_s && has_c)
          mode = m_s ? WM_SET : WM_CLR;
        else if (has_s && IS_PRIO[r])
          mode = WM_DIRECT;
        else
          mode = WM_BAD;
      end
    end
  end

endmodule

// File: rtl/ibank_fielddiff.sv
module ibank_fielddiff #(
  parameter int DW   = 8,
  parameter int FW   = 1,
  parameter int MAXF = 8
) (
  input  logic [DW-1:0]   old_v,
  input  logic [DW-1:0]   new_v,
  output logic [MAXF-1:0] chg,
  output logic [MAXF-1:0] en
);

  localparam int NF = DW / FW;

  for (genvar k = 0; k < MAXF; k++) begin : g_fld
    if (k < NF) begin : g_live
      localparam int LO = (NF - 1 - k) * FW;
      assign chg[k] = |(old_v[LO +: FW] ^ new_v[LO +: FW]);
      assign en[k]  = |new_v[LO +: FW];
    end else begin : g_none
      assign chg[k] = 1'b0;
      assign en[k]  = 1'b0;
    end
  end

endmodule

// File: rtl/ibank_walker.sv
module ibank_walker #(
  parameter int MAXF = 8,
  parameter int IDW  = 4,
  parameter logic [(1<<IDW)-1:0]          HAS_VEC = '0,
  parameter logic [(1<<IDW)-1:0][IDW-1:0] NEXT_ID = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [MAXF-1:0]           load_chg,
  input  logic [MAXF-1:0]           load_en,
  input  logic [MAXF-1:0][IDW-1:0]  load_ids,
  output logic                      busy,
  output logic                      ev_valid,
  output logic [IDW-1:0]            ev_id,
  output logic                      ev_inc
);

  localparam int KW = (MAXF > 1) ? $clog2(MAXF) : 1;

  logic [MAXF-1:0]          chg_q, en_q;
  logic [MAXF-1:0][IDW-1:0] ids_q;
  logic                     chain_q, cen_q;
  logic [IDW-1:0]           cur_q;

  logic [KW-1:0]  sel_k;
  logic           act_vld, act_grp, act_en, emit, cont;
  logic [IDW-1:0] act_id;

  assign busy = chain_q || (|chg_q);

  always_comb begin
    sel_k = '0;
    for (int k = MAXF - 1; k >= 0; k--)
      if (chg_q[k]) sel_k = KW'(k);
    if (chain_q) begin
      act_vld = 1'b1;
      act_id  = cur_q;
      act_grp = 1'b1;
      act_en  = cen_q;
    end else begin
      act_vld = |chg_q;
      act_id  = ids_q[sel_k];
      act_grp = 1'b0;
      act_en  = en_q[sel_k];
    end
    emit = act_vld && (act_id != '0) && HAS_VEC[act_id];
    cont = act_vld && (act_id != '0) && (NEXT_ID[act_id] != '0) &&
           (act_grp || !HAS_VEC[act_id]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q    <= '0;
      en_q     <= '0;
      ids_q    <= '0;
      chain_q  <= 1'b0;
      cen_q    <= 1'b0;
      cur_q    <= '0;
      ev_valid <= 1'b0;
      ev_id    <= '0;
      ev_inc   <= 1'b0;
    end else if (load) begin
      chg_q    <= load_chg;
      en_q     <= load_en;
      ids_q    <= load_ids;
      chain_q  <= 1'b0;
      ev_valid <= 1'b0;
    end else begin
      ev_valid <= emit;
      ev_id    <= act_id;
      ev_inc   <= act_en;
      if (!chain_q && (|chg_q)) chg_q[sel_k] <= 1'b0;
      chain_q  <= cont;
      cur_q    <= NEXT_ID[act_id];
      cen_q    <= act_en;
    end
  end

  // R10: an event only follows a cycle in which work was outstanding
  assert_evt_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(busy));

  // R8: a chain step never starts from an idle walker without a load
  assert_chain_from_work_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> !chain_q);

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
  import intc_bank_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int DW   = 8,
  parameter int IDW  = 4,
  parameter logic [NREG-1:0][AW-1:0] SET_ADDR =
    {32'h0000_0070, 32'h0000_0060, 32'h0000_0050, 32'h0000_0040},
  parameter logic [NREG-1:0][AW-1:0] CLR_ADDR =
    {32'h0000_0000, 32'h0000_0064, 32'h0000_0000, 32'h0000_0044},
  parameter logic [NREG-1:0]         IS_PRIO  = 4'b0110,
  parameter logic [NREG-1:0][3:0]    FW_CFG   = {4'd1, 4'd4, 4'd4, 4'd1},
  parameter logic [NREG-1:0][DW-1:0][IDW-1:0] FIELD_ID =
    128'h87654321_000000F6_00000054_E790A321,
  parameter logic [(1<<IDW)-1:0]          HAS_VEC = 16'hA9FE,
  parameter logic [(1<<IDW)-1:0][IDW-1:0] NEXT_ID = 64'h070D_CB00_8000_0000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_ready,
  output logic           wr_err,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           ev_valid,
  output logic [IDW-1:0] ev_id,
  output logic           ev_inc
);

  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int MAXF = DW;

  logic [NREG-1:0][DW-1:0] val_q;

  logic          w_hit, r_hit;
  logic [IW-1:0] w_idx, r_idx;
  wmode_e        w_mode, r_mode;

  ibank_decode #(.NREG(NREG), .AW(AW), .IW(IW), .SET_ADDR(SET_ADDR),
                 .CLR_ADDR(CLR_ADDR), .IS_PRIO(IS_PRIO))
    u_wdec (.addr(wr_addr), .hit(w_hit), .idx(w_idx), .mode(w_mode));

  ibank_decode #(.NREG(NREG), .AW(AW), .IW(IW), .SET_ADDR(SET_ADDR),
                 .CLR_ADDR(CLR_ADDR), .IS_PRIO(IS_PRIO))
    u_rdec (.addr(rd_addr), .hit(r_hit), .idx(r_idx), .mode(r_mode));

  wmode_e unused_rmode;
  assign unused_rmode = r_mode;

  logic          busy, acc, good;
  logic [DW-1:0] old_v, nxt_v;

  assign wr_ready = !busy;
  assign acc      = wr_en && wr_ready;
  assign old_v    = val_q[w_idx];

  always_comb begin
    good  = 1'b1;
    nxt_v = old_v;
    unique case (w_mode)
      WM_SET:    nxt_v = old_v | wr_data;
      WM_CLR:    nxt_v = old_v & ~wr_data;
      WM_DIRECT: nxt_v = wr_data;
      default:   good  = 1'b0;
    endcase
  end

  // per-register field comparators, each with its own field width
  logic [NREG-1:0][MAXF-1:0] chg_all, en_all;
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    ibank_fielddiff #(.DW(DW), .FW(int'(FW_CFG[r])), .MAXF(MAXF))
      u_diff (.old_v(val_q[r]), .new_v(nxt_v),
              .chg(chg_all[r]), .en(en_all[r]));

    // R3: a set-address write never drops a bit
    assert_set_keeps_bits_R3: assert property (@(posedge clk) disable iff (rst)
      (acc && w_idx == IW'(r) && w_mode == WM_SET) |=>
        ((val_q[r] & $past(val_q[r])) == $past(val_q[r])));

    // R3: a clear-address write never raises a bit
    assert_clr_no_new_bits_R3: assert property (@(posedge clk) disable iff (rst)
      (acc && w_idx == IW'(r) && w_mode == WM_CLR) |=>
        ((val_q[r] & ~$past(val_q[r])) == '0));
  end

  ibank_walker #(.MAXF(MAXF), .IDW(IDW), .HAS_VEC(HAS_VEC), .NEXT_ID(NEXT_ID))
    u_walk (
      .clk(clk), .rst(rst),
      .load(acc && good),
      .load_chg(chg_all[w_idx]),
      .load_en(en_all[w_idx]),
      .load_ids(FIELD_ID[w_idx]),
      .busy(busy),
      .ev_valid(ev_valid), .ev_id(ev_id), .ev_inc(ev_inc)
    );

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      wr_err  <= 1'b0;
      rd_data <= '0;
    end else begin
      wr_err <= acc && !good;
      if (acc && good) val_q[w_idx] <= nxt_v;
      if (rd_en) rd_data <= r_hit ? val_q[r_idx] : '0;
    end
  end

  // R9: a write offered while busy leaves the bank untouched
  assert_held_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ready) |=> $stable(val_q));

  // R5: a refused write flags an error and stores nothing
  assert_bad_write_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && !good) |=> (wr_err && $stable(val_q)));

  // R4: an unmapped read returns zero
  assert_unmapped_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !r_hit) |=> (rd_data == '0));

endmodule

// File: tb/tb_intc_mask_bank.sv
module tb_intc_mask_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready, wr_err;
  logic        rd_en = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        ev_valid, ev_inc;
  logic [3:0]  ev_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_mask_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_err(wr_err), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ev_valid(ev_valid), .ev_id(ev_id), .ev_inc(ev_inc)
  );

  // Event byte: high nibble = increment flag, low nibble = identifier.
  // Slot 0 of ev sits in bits [7:0].
  typedef struct packed {
    logic [31:0] a;
    logic [7:0]  d;
    logic        err;
    logic [31:0] ra;
    logic [7:0]  rv;
    logic [3:0]  n;
    logic [63:0] ev;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{32'h0000_0040, 8'h80, 1'b0, 32'h0000_0044, 8'h80, 4'd1, 64'h11},
    '{32'hE000_0040, 8'h10, 1'b0, 32'h0000_0040, 8'h90, 4'd2, 64'h1D1B},
    '{32'h0000_0040, 8'h0A, 1'b0, 32'h0000_0040, 8'h9A, 4'd1, 64'h17},
    '{32'h0000_0040, 8'h05, 1'b0, 32'h0000_0040, 8'h9F, 4'd2, 64'h1817},
    '{32'h0000_0044, 8'hFF, 1'b0, 32'h0000_0040, 8'h00, 4'd6, 64'h0807_070D_0B01},
    '{32'h0000_0044, 8'h00, 1'b0, 32'h0000_0044, 8'h00, 4'd0, 64'h0},
    '{32'h0000_0040, 8'h00, 1'b0, 32'h0000_0040, 8'h00, 4'd0, 64'h0},
    '{32'h0000_0050, 8'h30, 1'b0, 32'h0000_0050, 8'h30, 4'd1, 64'h14},
    '{32'h0000_0050, 8'h70, 1'b0, 32'h0000_0050, 8'h70, 4'd1, 64'h14},
    '{32'h0000_0050, 8'h02, 1'b0, 32'h0000_0050, 8'h02, 4'd2, 64'h1504},
    '{32'h0000_0060, 8'h1F, 1'b0, 32'h0000_0060, 8'h1F, 4'd2, 64'h1F16},
    '{32'h0000_0064, 8'h0C, 1'b0, 32'h0000_0064, 8'h13, 4'd1, 64'h1F},
    '{32'h0000_0064, 8'h13, 1'b0, 32'h0000_0060, 8'h00, 4'd2, 64'h0F06},
    '{32'h0000_0070, 8'hFF, 1'b1, 32'h0000_0070, 8'h00, 4'd0, 64'h0},
    '{32'h0000_0100, 8'hFF, 1'b1, 32'h0000_0100, 8'h00, 4'd0, 64'h0},
    '{32'h0000_0040, 8'hFF, 1'b0, 32'h2000_0044, 8'hFF, 4'd8, 64'h1817_171D_1B13_1211}
  };

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] ev_log [16];
  int         ev_n = 0;

  always @(negedge clk) begin
    if (ev_valid) begin
      if (ev_n < 16) ev_log[ev_n] = {3'b000, ev_inc, ev_id};
      ev_n = ev_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] d,
                          output logic err);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    ev_n = 0;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    err = wr_err;
    while (!wr_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic       e;
    logic [7:0] v;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(wr_ready === 1'b1, "R1", "ready in reset", 64'(wr_ready), 64'h1);
    check(ev_valid === 1'b0, "R1", "ev_valid in reset", 64'(ev_valid), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check(wr_err === 1'b0 && rd_data === 8'h00, "R1", "err/rd after reset",
          64'({wr_err, rd_data}), 64'h0);
    do_read(32'h40, v); check(v === 8'h00, "R1", "reg0 reset", 64'(v), 64'h0);
    do_read(32'h50, v); check(v === 8'h00, "R1", "reg1 reset", 64'(v), 64'h0);
    do_read(32'h60, v); check(v === 8'h00, "R1", "reg2 reset", 64'(v), 64'h0);

    // Table: R2 alias, R3 set/clear, R4 direct and reads, R5 errors,
    // R6 field order and direction, R7 silent ids, R8 chains, R10 pulses
    for (int i = 0; i < NV; i++) begin
      do_write(TBL[i].a, TBL[i].d, e);
      check(e === TBL[i].err, "R5", $sformatf("vec %0d wr_err", i),
            64'(e), 64'(TBL[i].err));
      check(ev_n == int'(TBL[i].n), "R6", $sformatf("vec %0d event count", i),
            64'(ev_n), 64'(TBL[i].n));
      for (int j = 0; j < int'(TBL[i].n) && j < ev_n; j++)
        check(ev_log[j] === TBL[i].ev[j*8 +: 8], "R8",
              $sformatf("vec %0d event %0d", i, j),
              64'(ev_log[j]), 64'(TBL[i].ev[j*8 +: 8]));
      do_read(TBL[i].ra, v);
      check(v === TBL[i].rv, "R3", $sformatf("vec %0d readback", i),
            64'(v), 64'(TBL[i].rv));
    end

    // R9: a write offered during a walk is dropped
    @(negedge clk);
    ev_n = 0;
    wr_en = 1'b1; wr_addr = 32'h44; wr_data = 8'hFF;
    @(negedge clk);
    check(wr_ready === 1'b0, "R9", "ready low while walking",
          64'(wr_ready), 64'h0);
    wr_addr = 32'h50; wr_data = 8'hAA;
    @(negedge clk);
    wr_en = 1'b0;
    while (!wr_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check(ev_n == 8, "R9", "events of clear-all", 64'(ev_n), 64'd8);
    check(ev_log[0] === 8'h01 && ev_log[3] === 8'h0B, "R10", "decrement order",
          64'({ev_log[0], ev_log[3]}), 64'h010B);
    do_read(32'h50, v);
    check(v === 8'h02, "R9", "held write ignored", 64'(v), 64'h02);

    // R1: reset during a walk drops remaining events
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 32'h40; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ev_n = 0;
    repeat (20) @(negedge clk);
    check(ev_n == 0, "R1", "no events after reset", 64'(ev_n), 64'h0);
    check(wr_ready === 1'b1, "R1", "ready after reset", 64'(wr_ready), 64'h1);
    do_read(32'h40, v);
    check(v === 8'h00, "R1", "reg0 cleared by reset", 64'(v), 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule